// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a flash device that runs embedded program and erase operations on its own. After software or another engine has launched such an operation, a pulse on `start_i` hands the wait over to this block. It reads the device status byte in pairs and compares the toggle bit between the two reads of each pair. A toggle bit that stops changing means the operation has finished.

While the toggle bit keeps changing, the block looks at the exceeded-limit flag in the second read of the pair. A low flag means the device is still working, so another pair is read. A high flag is not trusted immediately, because toggling can stop in the same moment the flag rises. One more pair is read to settle it. If the toggle bit is steady on that re-check, the operation succeeded. If it still toggles, the operation failed: the block writes the clear command to the device and then reports the failure.

A host-side budget of toggling pairs guards against a device that never settles. `abort_i` drops an ongoing wait without a report. The next `start_i` then begins again from a fresh first pair.

Top module: `tbit_poll_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o`, `timeout_o`, `rd_req_o` and `wr_req_o` are all 0.
- R2: A `start_i` pulse while idle raises `busy_o` and `rd_req_o` on the next cycle. Every status read holds `rd_req_o` high until a cycle with `rd_ack_i` high, and the status byte is taken only in that cycle. Reads come in pairs, and the toggle bit is bit 6 of the status byte.
- R3: When bit 6 is equal in both reads of a pair, the block finishes with `fail_o`=0 and `timeout_o`=0 and issues no write.
- R4: When bit 6 differs within a pair and bit 5 (the exceeded-limit flag) of the second read is 0, the block reads a further pair.
- R5: When bit 6 differs and bit 5 of the second read is 1, exactly one re-check pair is read. If bit 6 is equal in the re-check pair, the block finishes with success and issues no write.
- R6: When bit 6 still differs in the re-check pair (whatever bit 5 is), the block drives `wr_req_o` with `wr_data_o`=0xF0 and holds it until `wr_ack_i`. It then finishes with `fail_o`=1.
- R7: When `max_polls_i`=N is nonzero, the Nth consecutive pair with bit 6 differing and bit 5 at 0 ends the wait with `timeout_o`=1, `fail_o`=0 and no write. When N is 0, there is no limit.
- R8: `abort_i` during a read, an evaluation or the clear write returns the block to idle on the next cycle without a completion. The next start begins with a plain first pair, with no pending re-check and a full budget.
- R9: `start_i` while busy has no effect on the sequence in progress.
- R10: `done_o` is high for exactly one cycle per finished wait. `fail_o` and `timeout_o` keep their values from that cycle until the next accepted start.
- R11: `rd_req_o` and `wr_req_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a completion wait (taken only when idle) |
| abort_i | input | 1 | Drop the current wait without a report |
| max_polls_i | input | CNT_W | Budget of toggling pairs with the flag low, 0 = unlimited |
| rd_req_o | output | 1 | Status read request, held until acknowledged |
| rd_ack_i | input | 1 | Status byte valid on `rd_data_i` this cycle |
| rd_data_i | input | DATA_W | Status byte from the device |
| wr_req_o | output | 1 | Clear-command write request, held until acknowledged |
| wr_ack_i | input | 1 | Clear write accepted |
| wr_data_o | output | DATA_W | Clear command value (0xF0) |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Last wait ended in a confirmed failure |
| timeout_o | output | 1 | Last wait ran out of its pair budget |

## Verification
The hardest path to reach from the ports is the re-check: it needs a pair that toggles with the flag high, followed by a pair that either settles or keeps toggling. An abort placed inside that re-check is harder still. A scripted status stub in the bench serves a queue of bytes with a two-cycle response delay, and it presents inverted bytes outside acknowledged cycles. Each scenario therefore chooses the exact toggle and flag pattern, and a byte sampled early would change the outcome. The abort case waits until the first re-check read has been answered before it aborts. It then restarts with a toggling first pair, which would give a failure if the pending re-check had survived.

// File: rtl/tbit_poll_pkg.sv
package tbit_poll_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_A,
      ST_RD_B,
      ST_JUDGE,
      ST_CLEAR,
      ST_REPORT
   } poll_st_e;

endpackage

// File: rtl/tbit_pair_sampler.sv
module tbit_pair_sampler #(
   parameter int DATA_W     = 8,
   parameter int TOGGLE_POS = 6,
   parameter int FLAG_POS   = 5,
   parameter bit KEEP_WHOLE = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cap_a_i,
   input  logic              cap_b_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              toggled_o,
   output logic              flag_o
);

   if (TOGGLE_POS >= DATA_W || FLAG_POS >= DATA_W) begin : g_bad_pos
      $error("status bit position outside the status byte");
   end
   if (TOGGLE_POS == FLAG_POS) begin : g_same_pos
      $error("toggle bit and flag bit must differ");
   end

   if (KEEP_WHOLE) begin : g_whole
      logic [DATA_W-1:0] a_q, b_q;
      logic              unused_rest;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            a_q <= '0;
            b_q <= '0;
         end else begin
            if (cap_a_i) a_q <= data_i;
            if (cap_b_i) b_q <= data_i;
         end
      end
      assign toggled_o   = a_q[TOGGLE_POS] ^ b_q[TOGGLE_POS];
      assign flag_o      = b_q[FLAG_POS];
      assign unused_rest = ^{a_q, b_q};
   end else begin : g_bits
      logic a_tb_q, b_tb_q, b_fl_q;
      logic unused_rest;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            a_tb_q <= 1'b0;
            b_tb_q <= 1'b0;
            b_fl_q <= 1'b0;
         end else begin
            if (cap_a_i) a_tb_q <= data_i[TOGGLE_POS];
            if (cap_b_i) begin
               b_tb_q <= data_i[TOGGLE_POS];
               b_fl_q <= data_i[FLAG_POS];
            end
         end
      end
      assign toggled_o   = a_tb_q ^ b_tb_q;
      assign flag_o      = b_fl_q;
      assign unused_rest = ^data_i;
   end

   // R2
   hold_between_caps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cap_a_i && !cap_b_i) |=> ($stable(toggled_o) && $stable(flag_o)));

endmodule

// File: rtl/tbit_pair_budget.sv
module tbit_pair_budget #(
   parameter int CNT_W    = 16,
   parameter bit LIMIT_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             last_o
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
      $error("pair budget width must be 1..32");
   end

   if (LIMIT_EN) begin : g_limited
      localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     cnt_q <= '0;
         else if (clr_i)  cnt_q <= '0;
         else if (inc_i)  cnt_q <= cnt_q + ONE;
      end
      assign last_o = (limit_i != '0) && (cnt_q == limit_i - ONE);
   end else begin : g_unlimited
      logic unused_limit;
      assign unused_limit = ^{limit_i, clr_i, inc_i};
      assign last_o       = 1'b0;
   end

   // R7
   no_budget_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_i |-> !last_o);

endmodule

// File: rtl/tbit_poll_ctrl.sv
module tbit_poll_ctrl import tbit_poll_pkg::*; #(
   parameter int               DATA_W     = 8,
   parameter int               TOGGLE_POS = 6,
   parameter int               FLAG_POS   = 5,
   parameter int               CNT_W      = 16,
   parameter logic [DATA_W-1:0] CLEAR_CMD = 'hF0,
   parameter bit               KEEP_WHOLE = 1'b0,
   parameter bit               LIMIT_EN   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic [CNT_W-1:0]  max_polls_i,
   output logic              rd_req_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_req_o,
   input  logic              wr_ack_i,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o,
   output logic              timeout_o
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("status byte must be at least two bits wide");
   end

   poll_st_e st_q, st_d;
   logic     recheck_q, recheck_d;
   logic     fail_q, fail_d;
   logic     tmo_q, tmo_d;
   logic     cap_a, cap_b;
   logic     toggled, flag;
   logic     budget_clr, budget_inc, budget_last;
   logic     abortable;

   assign cap_a = (st_q == ST_RD_A) && rd_ack_i;
   assign cap_b = (st_q == ST_RD_B) && rd_ack_i;

   tbit_pair_sampler #(
      .DATA_W    (DATA_W),
      .TOGGLE_POS(TOGGLE_POS),
      .FLAG_POS  (FLAG_POS),
      .KEEP_WHOLE(KEEP_WHOLE)
   ) u_sampler (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cap_a_i  (cap_a),
      .cap_b_i  (cap_b),
      .data_i   (rd_data_i),
      .toggled_o(toggled),
      .flag_o   (flag)
   );

   assign budget_clr = (st_q == ST_IDLE) && start_i;
   assign budget_inc = (st_q == ST_JUDGE) && toggled && !recheck_q && !flag && !budget_last;

   tbit_pair_budget #(
      .CNT_W   (CNT_W),
      .LIMIT_EN(LIMIT_EN)
   ) u_budget (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (budget_clr),
      .inc_i  (budget_inc),
      .limit_i(max_polls_i),
      .last_o (budget_last)
   );

   assign abortable = (st_q == ST_RD_A) || (st_q == ST_RD_B) ||
                      (st_q == ST_JUDGE) || (st_q == ST_CLEAR);

   always_comb begin
      st_d      = st_q;
      recheck_d = recheck_q;
      fail_d    = fail_q;
      tmo_d     = tmo_q;
      case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               st_d      = ST_RD_A;
               recheck_d = 1'b0;
               fail_d    = 1'b0;
               tmo_d     = 1'b0;
            end
         end
         ST_RD_A: if (rd_ack_i) st_d = ST_RD_B;
         ST_RD_B: if (rd_ack_i) st_d = ST_JUDGE;
         ST_JUDGE: begin
            if (!toggled) begin
               st_d = ST_REPORT;
            end else if (recheck_q) begin
               st_d = ST_CLEAR;
            end else if (flag) begin
               recheck_d = 1'b1;
               st_d      = ST_RD_A;
            end else if (budget_last) begin
               tmo_d = 1'b1;
               st_d  = ST_REPORT;
            end else begin
               st_d = ST_RD_A;
            end
         end
         ST_CLEAR: begin
            if (wr_ack_i) begin
               fail_d = 1'b1;
               st_d   = ST_REPORT;
            end
         end
         ST_REPORT: st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
      if (abort_i && abortable) begin
         st_d      = ST_IDLE;
         recheck_d = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= ST_IDLE;
         recheck_q <= 1'b0;
         fail_q    <= 1'b0;
         tmo_q     <= 1'b0;
      end else begin
         st_q      <= st_d;
         recheck_q <= recheck_d;
         fail_q    <= fail_d;
         tmo_q     <= tmo_d;
      end
   end

   assign rd_req_o  = (st_q == ST_RD_A) || (st_q == ST_RD_B);
   assign wr_req_o  = (st_q == ST_CLEAR);
   assign wr_data_o = CLEAR_CMD;
   assign busy_o    = (st_q != ST_IDLE);
   assign done_o    = (st_q == ST_REPORT);
   assign fail_o    = fail_q;
   assign timeout_o = tmo_q;

   // R11
   rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_req_o && wr_req_o));

   // R10
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R2
   rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req_o && !rd_ack_i && !abort_i) |=> rd_req_o);

   // R6
   clear_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_o && !wr_ack_i && !abort_i) |=> wr_req_o);

   // R6
   fail_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fail_o) |-> $past(wr_ack_i));

   // R9
   start_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((st_q == ST_RD_B) && start_i && !rd_ack_i && !abort_i) |=> (st_q == ST_RD_B));

   // R8
   abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (abort_i && abortable) |=> (!busy_o && !done_o));

endmodule

// File: tb/sim_tbit_poll_ctrl.sv
`timescale 1ns/1ps
module sim_tbit_poll_ctrl;

   typedef struct {
      logic  fail;
      logic  tmo;
      int    nrd;
      int    nwr;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        abort = 1'b0;
   logic [15:0] max_polls = '0;
   logic        rd_req, rd_ack;
   logic [7:0]  rd_data;
   logic        wr_req, wr_ack;
   logic [7:0]  wr_data;
   logic        busy, done, fail, tmo;

   int          checks = 0;
   int          fails = 0;
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   int          results_seen = 0;
   int          lat = 0;
   logic [7:0]  last_b = 8'h00;
   logic [7:0]  wr_last = 8'h00;
   logic        done_prev = 1'b0;
   logic [7:0]  script[$];
   exp_t        exp_q[$];

   always #2.5 clk = ~clk;

   tbit_poll_ctrl u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .start_i    (start),
      .abort_i    (abort),
      .max_polls_i(max_polls),
      .rd_req_o   (rd_req),
      .rd_ack_i   (rd_ack),
      .rd_data_i  (rd_data),
      .wr_req_o   (wr_req),
      .wr_ack_i   (wr_ack),
      .wr_data_o  (wr_data),
      .busy_o     (busy),
      .done_o     (done),
      .fail_o     (fail),
      .timeout_o  (tmo)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // status stub: two idle cycles before each answer, inverted bytes outside answers
   always @(posedge clk) begin
      if (!rst_n) begin
         rd_ack  <= 1'b0;
         rd_data <= 8'hFF;
         lat     <= 0;
      end else if (rd_req && !rd_ack) begin
         if (lat == 2) begin
            if (script.size() > 0) last_b = script.pop_front();
            rd_ack  <= 1'b1;
            rd_data <= last_b;
            rd_cnt  <= rd_cnt + 1;
            lat     <= 0;
         end else begin
            rd_ack  <= 1'b0;
            rd_data <= ~last_b;
            lat     <= lat + 1;
         end
      end else begin
         rd_ack  <= 1'b0;
         rd_data <= ~last_b;
         lat     <= 0;
      end
   end

   // clear-write stub
   always @(posedge clk) begin
      if (!rst_n) begin
         wr_ack <= 1'b0;
      end else if (wr_req && !wr_ack) begin
         wr_ack  <= 1'b1;
         wr_cnt  <= wr_cnt + 1;
         wr_last <= wr_data;
         chk(!rd_req, "R11", "read request during clear write", int'(rd_req), 0);
      end else begin
         wr_ack <= 1'b0;
      end
   end

   // monitor: pops the expected result at every completion
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && done_prev)
            chk(1'b0, "R10", "done longer than one cycle", 2, 1);
         if (done) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8", "completion with nothing expected", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(fail == e.fail, e.tag, "fail_o", int'(fail), int'(e.fail));
               chk(tmo == e.tmo, e.tag, "timeout_o", int'(tmo), int'(e.tmo));
               chk(rd_cnt == e.nrd, e.tag, "status reads", rd_cnt, e.nrd);
               chk(wr_cnt == e.nwr, e.tag, "clear writes", wr_cnt, e.nwr);
               if (e.nwr > 0)
                  chk(wr_last == 8'hF0, e.tag, "clear command", int'(wr_last), 'hF0);
            end
            results_seen++;
         end
      end
      done_prev = done;
   end

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic run_case(input logic ef, input logic et, input int enr,
                           input int enw, input logic [15:0] mp, input string tag);
      exp_t e;
      int   seen;
      e.fail = ef; e.tmo = et; e.nrd = enr; e.nwr = enw; e.tag = tag;
      @(negedge clk);
      max_polls = mp;
      rd_cnt    = 0;
      wr_cnt    = 0;
      exp_q.push_back(e);
      seen = results_seen;
      pulse_start();
      chk(busy && rd_req, "R2", "busy and read request after start",
          int'(busy && rd_req), 1);
      wait (results_seen != seen);
      @(negedge clk);
   endtask

   task automatic add2(input logic [7:0] a, input logic [7:0] b);
      script.push_back(a);
      script.push_back(b);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !fail && !tmo, "R1", "status outputs in reset",
          int'({busy, done, fail, tmo}), 0);
      chk(!rd_req && !wr_req, "R1", "requests in reset", int'({rd_req, wr_req}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !rd_req, "R1", "idle after reset", int'({busy, rd_req}), 0);

      // R3 steady toggle bit in the first pair
      script.delete(); add2(8'h44, 8'h44);
      run_case(1'b0, 1'b0, 2, 0, 16'd0, "R3");

      // R4 toggling with flag low keeps polling
      script.delete(); add2(8'h40, 8'h00); add2(8'h00, 8'h40); add2(8'h08, 8'h08);
      run_case(1'b0, 1'b0, 6, 0, 16'd0, "R4");

      // R5 flag high, re-check pair steady
      script.delete(); add2(8'h00, 8'h60); add2(8'h60, 8'h60);
      run_case(1'b0, 1'b0, 4, 0, 16'd0, "R5");

      // R6 flag high, re-check pair still toggles
      script.delete(); add2(8'h00, 8'h60); add2(8'h20, 8'h60);
      run_case(1'b1, 1'b0, 4, 1, 16'd0, "R6");
      repeat (3) @(negedge clk);
      chk(fail == 1'b1, "R10", "fail_o held after completion", int'(fail), 1);

      // R6 re-check toggling with flag low is still a failure
      script.delete(); add2(8'h00, 8'h60); add2(8'h00, 8'h40);
      run_case(1'b1, 1'b0, 4, 1, 16'd0, "R6");

      // R7 budget of three toggling pairs
      script.delete();
      for (int i = 0; i < 5; i++) add2(8'h00, 8'h40);
      run_case(1'b0, 1'b1, 6, 0, 16'd3, "R7");
      repeat (3) @(negedge clk);
      chk(tmo == 1'b1, "R10", "timeout_o held after completion", int'(tmo), 1);

      // R7 budget of one pair (boundary)
      script.delete(); add2(8'h00, 8'h40); add2(8'h00, 8'h40);
      run_case(1'b0, 1'b1, 2, 0, 16'd1, "R7");

      // R7 zero budget means no limit
      script.delete();
      for (int i = 0; i < 5; i++) add2(8'h00, 8'h40);
      add2(8'h11, 8'h11);
      run_case(1'b0, 1'b0, 12, 0, 16'd0, "R7");
      chk(tmo == 1'b0 && fail == 1'b0, "R10", "flags cleared by new start",
          int'({fail, tmo}), 0);

      // R9 start during the second read of the first pair is ignored
      script.delete(); add2(8'h00, 8'h40); add2(8'h00, 8'h40); add2(8'h11, 8'h11);
      fork
         run_case(1'b0, 1'b0, 6, 0, 16'd0, "R9");
         begin
            wait (rd_cnt == 1);
            pulse_start();
         end
      join

      // R8 abort inside the re-check, then restart with a toggling first pair
      script.delete(); add2(8'h00, 8'h60);
      @(negedge clk);
      rd_cnt = 0;
      max_polls = 16'd0;
      pulse_start();
      wait (rd_cnt == 3);
      @(negedge clk) abort = 1'b1;
      @(negedge clk) abort = 1'b0;
      chk(!busy && !rd_req, "R8", "idle after abort", int'({busy, rd_req}), 0);
      repeat (8) @(negedge clk);
      chk(!busy, "R8", "still idle without completion", int'(busy), 0);
      script.delete(); add2(8'h00, 8'h40); add2(8'h11, 8'h11);
      run_case(1'b0, 1'b0, 4, 0, 16'd0, "R8");

      chk(exp_q.size() == 0, "R10", "completions outstanding", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule